// File: doc/BRIEF.md
# Four-Lane XAUI Receive Clock-Compensation and Character Mapper

This block sits behind lane deskew on a four-lane XAUI receiver. Each lane presents one decoded symbol per column: a byte, a flag saying the byte is a control code, and a flag saying the decoder saw a code violation. Whole columns enter a single shared FIFO when the write strobe is high and leave it when the read strobe is high. The two strobes stand for the recovered-clock and local-clock rates, so the fill level drifts when the rates differ by up to ±100 ppm. The circuit that carries data across the two clock domains lies outside this block, and so the block runs on one clock with two strobes.

The block holds the fill level near the middle of the FIFO. It never cuts into a frame. If the level climbs above the upper mark, the next incoming column in which all four lanes carry idle codes is dropped before it is stored. If the level sits below the lower mark and the previous column sent out was idle, a read produces an extra idle column and the FIFO is not popped. Every column that leaves is translated lane by lane into an XGMII control bit and character. Invalid symbols become the error character.

Pulse outputs mark each insertion and each deletion. Sticky flags record overflow and underflow. While lane alignment is low, the FIFO is flushed and the output shows idle on every lane.

Top module: `xaui_rate_match`

## Requirements
- R1: A lane with the control flag 0 and the violation flag 0 is output with its XGMII control bit at 0 and its byte unchanged. Lane i uses `rxd[8i+7:8i]` and `rxc[i]`.
- R2: A control symbol with byte 0x1C, 0x7C or 0xBC is output as control bit 1 with character 0x07.
- R3: Control bytes 0x9C, 0xFB, 0xFD and 0xFE are output as control bit 1 with the same value (sequence, start, terminate, error).
- R4: A lane with the violation flag set, or a control symbol whose byte is in none of the lists above, is output as control bit 1 with character 0xFE.
- R5: Stored columns leave in arrival order, one per accepted read. `rx_valid` goes high in the cycle after every read while aligned. The outputs hold their value when no read occurs.
- R6: A read taken while the fill is below LO_MARK (5) and the last output column was idle produces an idle column (all control bits 1, all characters 0x07). That read pops nothing, and `ins_pulse` rises in the same cycle as the inserted column.
- R7: A write taken while the fill is above HI_MARK (11), whose column is idle on all four lanes, is discarded. `del_pulse` is then high in the cycle after the write.
- R8: No column is inserted after a non-idle output column, and no column that is non-idle on any lane is deleted. Such reads pop and such writes store normally.
- R9: A write that is not deleted and finds the FIFO full (16 columns) is dropped, and it sets `ovf_flag`. The flag stays set until reset.
- R10: A read that is not an insertion and finds the FIFO empty outputs 0xFE with control bit 1 on every lane. It sets `unf_flag`, which stays set until reset.
- R11: While `align_ok` is 0, writes are ignored and the FIFO is emptied. The output becomes an idle column, `rx_valid` is 0, and no insertion or deletion occurs. When alignment returns, the last output counts as idle.
- R12: After reset the output is an idle column, `rx_valid`, both pulses and both flags are 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| align_ok | input | 1 | Lanes are deskewed and aligned |
| wr_en | input | 1 | One input column is offered this cycle |
| lane_byte | input | 32 | Decoded byte per lane, lane i at bits 8i+7:8i |
| lane_ctrl | input | 4 | Per-lane control-code flag |
| lane_err | input | 4 | Per-lane code-violation flag |
| rd_en | input | 1 | Local side takes one column this cycle |
| rx_valid | output | 1 | A column was read in the previous cycle |
| rxd | output | 32 | XGMII receive characters |
| rxc | output | 4 | XGMII receive control bits |
| ins_pulse | output | 1 | The current output column is an inserted idle |
| del_pulse | output | 1 | An idle column was dropped on the previous write |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The bench builds the block with its defaults: four lanes, a FIFO 16 columns deep, a lower mark of 5 and an upper mark of 11. With a FIFO this shallow, a few hundred cycles of unequal write and read rates push the fill across both marks and drive it to full and to empty. Deletion, insertion, overflow and mid-frame underflow therefore all occur many times in a short random run. Directed sequences reach the mapping of every listed control byte, of invalid control bytes and of violations, as well as an underflow right after a frame drains and an alignment drop in the middle of traffic.

// File: rtl/xaui_rm_pkg.sv
package xaui_rm_pkg;

  // one lane symbol: {violation, control flag, byte}
  localparam int LANE_W = 10;

  typedef struct packed {
    logic       err;
    logic       ctl;
    logic [7:0] dat;
  } lane_sym_t;

  // XGMII characters
  localparam logic [7:0] XG_IDLE  = 8'h07;
  localparam logic [7:0] XG_SEQ   = 8'h9C;
  localparam logic [7:0] XG_START = 8'hFB;
  localparam logic [7:0] XG_TERM  = 8'hFD;
  localparam logic [7:0] XG_ERR   = 8'hFE;

  // decoded control bytes
  localparam logic [7:0] KB_IDLE_A = 8'h1C;
  localparam logic [7:0] KB_IDLE_B = 8'h7C;
  localparam logic [7:0] KB_IDLE_C = 8'hBC;
  localparam logic [7:0] KB_SEQ    = 8'h9C;
  localparam logic [7:0] KB_START  = 8'hFB;
  localparam logic [7:0] KB_TERM   = 8'hFD;
  localparam logic [7:0] KB_ERR    = 8'hFE;

  function automatic logic sym_is_idle(lane_sym_t s);
    return !s.err && s.ctl &&
           (s.dat == KB_IDLE_A || s.dat == KB_IDLE_B || s.dat == KB_IDLE_C);
  endfunction

endpackage

// File: rtl/rm_char_map.sv
module rm_char_map
  import xaui_rm_pkg::*;
(
  input  lane_sym_t  sym,
  output logic       xg_c,
  output logic [7:0] xg_d
);

  always_comb begin
    xg_c = 1'b1;
    xg_d = XG_ERR;
    if (sym.err) begin
      xg_c = 1'b1;
      xg_d = XG_ERR;
    end else if (!sym.ctl) begin
      xg_c = 1'b0;
      xg_d = sym.dat;
    end else begin
      unique case (sym.dat)
        KB_IDLE_A, KB_IDLE_B, KB_IDLE_C: xg_d = XG_IDLE;
        KB_SEQ:                          xg_d = XG_SEQ;
        KB_START:                        xg_d = XG_START;
        KB_TERM:                         xg_d = XG_TERM;
        KB_ERR:                          xg_d = XG_ERR;
        default:                         xg_d = XG_ERR;
      endcase
    end
  end

endmodule

// File: rtl/rm_col_idle.sv
module rm_col_idle
  import xaui_rm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*LANE_W-1:0] col,
  output logic                    all_idle
);

  logic [LANES-1:0] lane_idle;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_idle[g] = sym_is_idle(lane_sym_t'(col[g*LANE_W +: LANE_W]));
  end

  assign all_idle = &lane_idle;

endmodule

// File: rtl/rm_col_fifo.sv
module rm_col_fifo #(
  parameter int WIDTH = 40,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    fill,
  output logic             full,
  output logic             empty
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rp];
  assign fill  = cnt;
  assign full  = (cnt == DEPTH_C);
  assign empty = (cnt == '0);

  // R9
  fifo_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R10
  fifo_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEPTH_C);

endmodule

// File: rtl/xaui_rate_match.sv
module xaui_rate_match
  import xaui_rm_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int DEPTH   = 16,
  parameter int LO_MARK = 5,
  parameter int HI_MARK = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               align_ok,
  input  logic               wr_en,
  input  logic [8*LANES-1:0] lane_byte,
  input  logic [LANES-1:0]   lane_ctrl,
  input  logic [LANES-1:0]   lane_err,
  input  logic               rd_en,
  output logic               rx_valid,
  output logic [8*LANES-1:0] rxd,
  output logic [LANES-1:0]   rxc,
  output logic               ins_pulse,
  output logic               del_pulse,
  output logic               ovf_flag,
  output logic               unf_flag
);

  localparam int COL_W = LANES * LANE_W;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0]      LO_C   = CW'(LO_MARK);
  localparam logic [CW-1:0]      HI_C   = CW'(HI_MARK);
  localparam logic [8*LANES-1:0] IDLE_D = {LANES{XG_IDLE}};
  localparam logic [8*LANES-1:0] ERR_D  = {LANES{XG_ERR}};

  logic [COL_W-1:0]   in_col, head_col;
  logic               in_idle, head_idle;
  logic [CW-1:0]      fill;
  logic               full, empty;
  logic               del_col, ins_col, pop_col, push_col, unf_ev, ovf_ev;
  logic               last_idle;
  logic [8*LANES-1:0] map_d;
  logic [LANES-1:0]   map_c;

  // pack incoming lanes into a column
  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign in_col[g*LANE_W +: LANE_W] = {lane_err[g], lane_ctrl[g], lane_byte[g*8 +: 8]};
  end

  rm_col_idle #(.LANES(LANES)) u_in_idle (
    .col      (in_col),
    .all_idle (in_idle)
  );

  rm_col_idle #(.LANES(LANES)) u_head_idle (
    .col      (head_col),
    .all_idle (head_idle)
  );

  // compensation decisions
  always_comb begin
    del_col  = align_ok && wr_en && (fill > HI_C) && in_idle;
    ins_col  = align_ok && rd_en && (fill < LO_C) && last_idle;
    pop_col  = align_ok && rd_en && !ins_col && !empty;
    unf_ev   = align_ok && rd_en && !ins_col && empty;
    push_col = align_ok && wr_en && !del_col && !full;
    ovf_ev   = align_ok && wr_en && !del_col && full;
  end

  rm_col_fifo #(.WIDTH(COL_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (!align_ok),
    .push  (push_col),
    .wdata (in_col),
    .pop   (pop_col),
    .rdata (head_col),
    .fill  (fill),
    .full  (full),
    .empty (empty)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_map
    rm_char_map u_map (
      .sym  (lane_sym_t'(head_col[g*LANE_W +: LANE_W])),
      .xg_c (map_c[g]),
      .xg_d (map_d[g*8 +: 8])
    );
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid  <= 1'b0;
      rxd       <= IDLE_D;
      rxc       <= '1;
      ins_pulse <= 1'b0;
      del_pulse <= 1'b0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
      last_idle <= 1'b1;
    end else begin
      rx_valid  <= align_ok && rd_en;
      ins_pulse <= ins_col;
      del_pulse <= del_col;
      if (ovf_ev) ovf_flag <= 1'b1;
      if (unf_ev) unf_flag <= 1'b1;
      if (!align_ok) begin
        rxd       <= IDLE_D;
        rxc       <= '1;
        last_idle <= 1'b1;
      end else if (ins_col) begin
        rxd       <= IDLE_D;
        rxc       <= '1;
        last_idle <= 1'b1;
      end else if (pop_col) begin
        rxd       <= map_d;
        rxc       <= map_c;
        last_idle <= head_idle;
      end else if (unf_ev) begin
        rxd       <= ERR_D;
        rxc       <= '1;
        last_idle <= 1'b0;
      end
    end
  end

  // R6
  ins_idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    ins_pulse |-> (rx_valid && rxc == '1 && rxd == IDLE_D));

  // R7
  del_level_chk: assert property (@(posedge clk) disable iff (rst)
    del_pulse |-> ($past(fill) > HI_C));

  // R8
  del_idle_only_chk: assert property (@(posedge clk) disable iff (rst)
    del_pulse |-> ($past(lane_ctrl) == '1 && $past(lane_err) == '0));

  // R11
  unaligned_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !align_ok |=> (rxc == '1 && rxd == IDLE_D && !rx_valid && !ins_pulse && !del_pulse));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R10
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_flag |=> unf_flag);

endmodule

// File: tb/xaui_rate_match_test.sv
module xaui_rate_match_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL         = 4;
  localparam int DEPTH      = 16;
  localparam int LO         = 5;
  localparam int HI         = 11;
  localparam int WD_LIMIT   = 200000;

  logic        clk = 1'b0;
  logic        rst, align_ok, wr_en, rd_en;
  logic [31:0] lane_byte;
  logic [3:0]  lane_ctrl, lane_err;
  logic        rx_valid, ins_pulse, del_pulse, ovf_flag, unf_flag;
  logic [31:0] rxd;
  logic [3:0]  rxc;

  always #(CLK_PERIOD/2) clk = ~clk;

  xaui_rate_match uut (
    .clk(clk), .rst(rst), .align_ok(align_ok), .wr_en(wr_en),
    .lane_byte(lane_byte), .lane_ctrl(lane_ctrl), .lane_err(lane_err),
    .rd_en(rd_en), .rx_valid(rx_valid), .rxd(rxd), .rxc(rxc),
    .ins_pulse(ins_pulse), .del_pulse(del_pulse),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // reference model state
  logic [39:0] mq[$];
  bit          m_last_idle, m_ovf, m_unf;
  bit          e_valid, e_ins, e_del;
  logic [31:0] e_rxd;
  logic [3:0]  e_rxc;
  string       tag;

  // stimulus generator state
  int gen_mode = 0;
  int gen_len  = 0;

  function automatic logic [9:0] sym(logic [7:0] d, bit c, bit e);
    return {e, c, d};
  endfunction

  // {control bit, character}
  function automatic logic [8:0] ref_map(logic [9:0] s);
    if (s[9]) return {1'b1, 8'hFE};
    if (!s[8]) return {1'b0, s[7:0]};
    case (s[7:0])
      8'h1C, 8'h7C, 8'hBC: return {1'b1, 8'h07};
      8'h9C:               return {1'b1, 8'h9C};
      8'hFB:               return {1'b1, 8'hFB};
      8'hFD:               return {1'b1, 8'hFD};
      8'hFE:               return {1'b1, 8'hFE};
      default:             return {1'b1, 8'hFE};
    endcase
  endfunction

  function automatic bit sym_idle(logic [9:0] s);
    return !s[9] && s[8] && (s[7:0] == 8'h1C || s[7:0] == 8'h7C || s[7:0] == 8'hBC);
  endfunction

  function automatic bit col_idle(logic [39:0] c);
    for (int i = 0; i < NL; i++) if (!sym_idle(c[i*10 +: 10])) return 0;
    return 1;
  endfunction

  function automatic string col_tag(logic [39:0] c);
    bit bad = 0, named = 0, dat = 0;
    for (int i = 0; i < NL; i++) begin
      logic [9:0] s = c[i*10 +: 10];
      if (s[9]) bad = 1;
      else if (!s[8]) dat = 1;
      else if (s[7:0] inside {8'h9C, 8'hFB, 8'hFD, 8'hFE}) named = 1;
      else if (!sym_idle(s)) bad = 1;
    end
    if (bad) return "R4";
    if (named) return "R3";
    if (!dat) return "R2";
    return "R1/R5";
  endfunction

  function automatic logic [39:0] idle_col();
    logic [39:0] c;
    for (int i = 0; i < NL; i++) begin
      int k = $urandom % 3;
      c[i*10 +: 10] = sym(k == 0 ? 8'h1C : (k == 1 ? 8'h7C : 8'hBC), 1'b1, 1'b0);
    end
    return c;
  endfunction

  function automatic logic [39:0] data_col();
    logic [39:0] c;
    for (int i = 0; i < NL; i++) c[i*10 +: 10] = sym(8'($urandom), 1'b0, 1'b0);
    return c;
  endfunction

  task automatic gen_col(output logic [39:0] c);
    int r;
    if (gen_mode == 0) begin
      r = $urandom % 100;
      if (r < 15) begin
        c = data_col();
        c[9:0] = sym(8'hFB, 1'b1, 1'b0);
        gen_len  = 1 + $urandom % 6;
        gen_mode = 1;
      end else if (r < 20) begin
        c = data_col();
        c[9:0] = sym(8'h9C, 1'b1, 1'b0);
      end else if (r < 24) begin
        c = idle_col();
        if ($urandom % 2) c[($urandom % NL)*10 +: 10] = sym(8'($urandom), 1'b0, 1'b1);
        else c[($urandom % NL)*10 +: 10] = sym(8'h3C, 1'b1, 1'b0);
      end else begin
        c = idle_col();
      end
    end else if (gen_len > 0) begin
      c = data_col();
      if ($urandom % 50 == 0) c[($urandom % NL)*10 +: 10] = sym(8'h00, 1'b0, 1'b1);
      gen_len--;
    end else begin
      int k = $urandom % NL;
      c = data_col();
      for (int i = 0; i < NL; i++) begin
        if (i == k) c[i*10 +: 10] = sym(8'hFD, 1'b1, 1'b0);
        else if (i > k) c[i*10 +: 10] = sym(8'hBC, 1'b1, 1'b0);
      end
      gen_mode = 0;
    end
  endtask

  task automatic model_step(bit wr, bit rd, bit al, logic [39:0] col);
    int cnt = mq.size();
    bit del, ins, pop, unf, push, ovf;
    e_ins = 0;
    e_del = 0;
    if (!al) begin
      mq.delete();
      e_rxd = {4{8'h07}};
      e_rxc = 4'hF;
      e_valid = 0;
      m_last_idle = 1;
      tag = "R11";
      return;
    end
    del  = wr && cnt > HI && col_idle(col);
    ins  = rd && cnt < LO && m_last_idle;
    pop  = rd && !ins && cnt > 0;
    unf  = rd && !ins && cnt == 0;
    push = wr && !del && cnt < DEPTH;
    ovf  = wr && !del && cnt == DEPTH;
    tag = "R5";
    if (rd && cnt < LO && !m_last_idle) tag = "R8";
    if (wr && cnt > HI && !col_idle(col)) tag = "R8";
    if (ins) begin
      e_rxd = {4{8'h07}};
      e_rxc = 4'hF;
      m_last_idle = 1;
      tag = "R6";
    end else if (pop) begin
      logic [39:0] h = mq[0];
      for (int i = 0; i < NL; i++) begin
        logic [8:0] m = ref_map(h[i*10 +: 10]);
        e_rxc[i] = m[8];
        e_rxd[i*8 +: 8] = m[7:0];
      end
      m_last_idle = col_idle(h);
      if (tag == "R5") tag = col_tag(h);
    end else if (unf) begin
      e_rxd = {4{8'hFE}};
      e_rxc = 4'hF;
      m_last_idle = 0;
      m_unf = 1;
      tag = "R10";
    end
    if (pop) void'(mq.pop_front());
    if (push) mq.push_back(col);
    if (del) tag = "R7";
    if (ovf) begin
      m_ovf = 1;
      tag = "R9";
    end
    e_valid = rd;
    e_ins = ins;
    e_del = del;
  endtask

  task automatic check_outputs();
    checks++;
    if (rx_valid !== e_valid || rxd !== e_rxd || rxc !== e_rxc || ins_pulse !== e_ins ||
        del_pulse !== e_del || ovf_flag !== m_ovf || unf_flag !== m_unf) begin
      errors++;
      $display("FAIL %s t=%0t: got valid=%0b rxc=%h rxd=%h ins=%0b del=%0b ovf=%0b unf=%0b exp valid=%0b rxc=%h rxd=%h ins=%0b del=%0b ovf=%0b unf=%0b",
               tag, $time, rx_valid, rxc, rxd, ins_pulse, del_pulse, ovf_flag, unf_flag,
               e_valid, e_rxc, e_rxd, e_ins, e_del, m_ovf, m_unf);
    end
  endtask

  task automatic drive(bit wr, bit rd, bit al, logic [39:0] col);
    @(negedge clk);
    check_outputs();
    wr_en = wr;
    rd_en = rd;
    align_ok = al;
    for (int i = 0; i < NL; i++) begin
      lane_byte[i*8 +: 8] = col[i*10 +: 8];
      lane_ctrl[i] = col[i*10 + 8];
      lane_err[i]  = col[i*10 + 9];
    end
    model_step(wr, rd, al, col);
  endtask

  task automatic rand_phase(int n, int pw, int pr);
    for (int k = 0; k < n; k++) begin
      logic [39:0] c;
      bit w = ($urandom % 100) < pw;
      bit r = ($urandom % 100) < pr;
      if (w) gen_col(c);
      else c = idle_col();
      drive(w, r, 1'b1, c);
    end
  endtask

  task automatic report_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected under %0d", cyc, WD_LIMIT);
      report_and_end();
    end
  end

  initial begin
    logic [39:0] c;
    void'($urandom(32'd424242));
    rst = 1'b1; align_ok = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    lane_byte = '0; lane_ctrl = '0; lane_err = '0;
    mq.delete();
    m_last_idle = 1; m_ovf = 0; m_unf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    align_ok = 1'b1;
    e_valid = 0; e_ins = 0; e_del = 0;
    e_rxd = {4{8'h07}}; e_rxc = 4'hF;
    tag = "R12";
    // first comparison below is the R12 reset-state check

    // R11: traffic while unaligned
    for (int k = 0; k < 12; k++) drive(1'b1, k % 2 == 1, 1'b0, data_col());

    // R1 R2 R3 R4: directed mapping columns, then read them out
    c = {sym(8'h9C,1,0), sym(8'hBC,1,0), sym(8'h7C,1,0), sym(8'h1C,1,0)};
    drive(1, 0, 1, c);
    c = {sym(8'h55,0,0), sym(8'hFE,1,0), sym(8'hFD,1,0), sym(8'hFB,1,0)};
    drive(1, 0, 1, c);
    c = {sym(8'h07,0,0), sym(8'hF7,1,0), sym(8'h3C,1,0), sym(8'h00,0,1)};
    drive(1, 0, 1, c);
    c = {sym(8'h1C,0,0), sym(8'hFF,0,0), sym(8'h00,0,0), sym(8'hAA,0,0)};
    drive(1, 0, 1, c);
    drive(1, 0, 1, idle_col());
    for (int k = 0; k < 6; k++) drive(0, 1, 1, idle_col());

    // R10 R8: frame drains, then a read finds the FIFO empty mid-frame
    drive(0, 0, 0, idle_col());
    c = data_col(); c[9:0] = sym(8'hFB, 1, 0);
    drive(1, 0, 1, c);
    for (int k = 0; k < 4; k++) drive(1, 0, 1, data_col());
    for (int k = 0; k < 7; k++) drive(0, 1, 1, idle_col());

    // R9: long frame with no reads overflows the FIFO
    drive(0, 0, 0, idle_col());
    for (int k = 0; k < 20; k++) drive(1, 0, 1, data_col());
    for (int k = 0; k < 18; k++) drive(0, 1, 1, idle_col());

    // R7: idle columns written above the upper mark
    drive(0, 0, 0, idle_col());
    for (int k = 0; k < 16; k++) drive(1, 0, 1, idle_col());
    for (int k = 0; k < 10; k++) drive(0, 1, 1, idle_col());

    // R6: reads below the lower mark after idle output
    for (int k = 0; k < 8; k++) drive(0, 1, 1, idle_col());

    // random traffic with drifting rates
    gen_mode = 0;
    rand_phase(300, 50, 50);
    rand_phase(600, 85, 55);
    rand_phase(600, 50, 85);
    for (int k = 0; k < 10; k++) drive(1, 1, 0, data_col());
    rand_phase(400, 70, 70);
    rand_phase(300, 95, 30);
    rand_phase(300, 30, 95);

    @(negedge clk);
    check_outputs();
    report_and_end();
  end

endmodule